// File: doc/BRIEF.md
# Dual SRAM Self-Test Controller

This block holds one 32-bit control and status word that runs built-in self-test on two tightly coupled memories. One memory holds instructions and the other holds data. Software writes a test length, an enable bit and a pause bit for each memory. In the same word it can write a start strobe for either channel. Reading the word back gives the stored settings. In the bit positions that take strobes and reserved values on write, a read returns each channel's running, complete and fail status.

Each channel has its own sequencer. It first writes a pattern derived from the address into every word of the selected range. It then reads every word back and compares it with the pattern. The two channels are independent and can run at the same time. While a channel is enabled, the block drives that memory's normal-use enable low, because the test overwrites the memory's contents.

Top module: `sbist_ctl`

## Requirements
- R1: After reset the status word reads 0x00000000 and both normal-use enables are high.
- R2: Writable fields are: instruction size [31:21], enable [18], pause [17]; data size [15:5], enable [2], pause [1]. Writes to bits 20, 19, 4 and 3 have no effect. On read those bits return instruction complete (20), instruction fail (19), data complete (4) and data fail (3). Bits 16 and 0 read as instruction running and data running.
- R3: A size value N selects 2^N 32-bit words (2^(N+2) bytes). N=0 is treated as 1, and N above the channel's address width is clamped to that width. An accepted start keeps running high for exactly 2·W+1 cycles, where W is the word count.
- R4: Writing 1 to bit 16 (instruction) or bit 0 (data) starts that channel only if its enable bit was already set before the write and the channel is idle. Any other start write is ignored.
- R5: Each normal-use enable output is the inverse of that channel's stored enable bit.
- R6: A run writes addresses 0 to W-1 in ascending order, then reads them back in the same order. The word at address a is (a<<16) XOR ~a XOR 0x3C3CA5A5, with a zero-extended to 32 bits. Read data arrives one cycle after the read strobe.
- R7: While a channel's pause bit is set, that sequencer issues no memory access and holds its address. When pause is cleared it continues from the same point.
- R8: Any read-back mismatch sets fail, and the run still completes and sets complete. Complete and fail stay set until the next accepted start clears them both.
- R9: The two channels run concurrently without affecting each other's timing or flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Control and status read data |
| inst_use_en | output | 1 | Instruction memory normal-use enable |
| data_use_en | output | 1 | Data memory normal-use enable |
| inst_mem_we | output | 1 | Instruction memory write strobe |
| inst_mem_re | output | 1 | Instruction memory read strobe |
| inst_mem_addr | output | I_AW | Instruction memory word address |
| inst_mem_wdata | output | 32 | Instruction memory write data |
| inst_mem_rdata | input | 32 | Instruction memory read data (one-cycle latency) |
| data_mem_we | output | 1 | Data memory write strobe |
| data_mem_re | output | 1 | Data memory read strobe |
| data_mem_addr | output | D_AW | Data memory word address |
| data_mem_wdata | output | 32 | Data memory write data |
| data_mem_rdata | input | 32 | Data memory read data (one-cycle latency) |

## Verification
The bench builds the block with I_AW=6 (64 words) and D_AW=4 (16 words). With these sizes, full runs take only a few dozen cycles, so the exact run length of 2·W+1 can be counted for every size tested. The 16-word data memory lets a size code of 9 reach the clamp, and a size code of 0 exercises the lower bound. The bench's memory models can flip one bit at a chosen address to provoke a mismatch.

// File: rtl/sbist_pkg.sv
package sbist_pkg;

    localparam int WORD_W = 32;
    localparam int SIZE_W = 11;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_WRITE = 2'd1,
        PH_READ  = 2'd2,
        PH_DRAIN = 2'd3
    } sbist_phase_e;

    typedef struct packed {
        logic [SIZE_W-1:0] size;
        logic              en;
        logic              pause;
    } sbist_cfg_t;

    // Address-derived test word
    function automatic logic [WORD_W-1:0] sbist_pattern(input logic [WORD_W-1:0] a);
        return (a << 16) ^ ~a ^ 32'h3C3C_A5A5;
    endfunction

endpackage

// File: rtl/sbist_size_dec.sv
module sbist_size_dec #(
    parameter int AW = 10
) (
    input  logic [sbist_pkg::SIZE_W-1:0] size_i,
    output logic [AW-1:0]                last_addr_o
);
    localparam int SW = sbist_pkg::SIZE_W;

    int eff;

    always_comb begin
        if ({{(32-SW){1'b0}}, size_i} > 32'(AW)) begin
            eff = AW;
        end else if (size_i == '0) begin
            eff = 1;
        end else begin
            eff = int'({{(32-SW){1'b0}}, size_i});
        end
        last_addr_o = AW'((64'd1 << eff) - 64'd1);
    end

endmodule

// File: rtl/sbist_seq.sv
module sbist_seq
    import sbist_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              pause_i,
    input  logic [SIZE_W-1:0] size_i,
    output logic              run_o,
    output logic              done_o,
    output logic              fail_o,
    output logic              mem_we_o,
    output logic              mem_re_o,
    output logic [AW-1:0]     mem_addr_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    input  logic [WORD_W-1:0] mem_rdata_i
);
    typedef struct packed {
        sbist_phase_e  phase;
        logic [AW-1:0] addr;
        logic [AW-1:0] last;
        logic          chk_vld;
        logic [AW-1:0] chk_addr;
        logic          done;
        logic          fail;
    } seq_state_t;

    seq_state_t    seq_d, seq_q;
    logic [AW-1:0] last_dec;

    sbist_size_dec #(.AW(AW)) u_size_dec (
        .size_i      (size_i),
        .last_addr_o (last_dec)
    );

    always_comb begin
        seq_d       = seq_q;
        mem_we_o    = !pause_i && (seq_q.phase == PH_WRITE);
        mem_re_o    = !pause_i && (seq_q.phase == PH_READ);
        mem_addr_o  = seq_q.addr;
        mem_wdata_o = sbist_pattern(32'(seq_q.addr));

        seq_d.chk_vld  = mem_re_o;
        seq_d.chk_addr = seq_q.addr;
        if (seq_q.chk_vld && (mem_rdata_i != sbist_pattern(32'(seq_q.chk_addr)))) begin
            seq_d.fail = 1'b1;
        end

        unique case (seq_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    seq_d.phase   = PH_WRITE;
                    seq_d.addr    = '0;
                    seq_d.last    = last_dec;
                    seq_d.done    = 1'b0;
                    seq_d.fail    = 1'b0;
                    seq_d.chk_vld = 1'b0;
                end
            end
            PH_WRITE: begin
                if (!pause_i) begin
                    if (seq_q.addr == seq_q.last) begin
                        seq_d.phase = PH_READ;
                        seq_d.addr  = '0;
                    end else begin
                        seq_d.addr = seq_q.addr + 1'b1;
                    end
                end
            end
            PH_READ: begin
                if (!pause_i) begin
                    if (seq_q.addr == seq_q.last) begin
                        seq_d.phase = PH_DRAIN;
                    end else begin
                        seq_d.addr = seq_q.addr + 1'b1;
                    end
                end
            end
            PH_DRAIN: begin
                seq_d.phase = PH_IDLE;
                seq_d.done  = 1'b1;
            end
            default: seq_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{phase: PH_IDLE, default: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign run_o  = (seq_q.phase != PH_IDLE);
    assign done_o = seq_q.done;
    assign fail_o = seq_q.fail;

    // R7: a paused channel touches no memory and keeps its address
    a_r7_pause_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        pause_i |-> !(mem_we_o || mem_re_o));
    a_r7_pause_holds_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_i && (seq_q.phase == PH_WRITE || seq_q.phase == PH_READ)) |=> $stable(mem_addr_o));
    // R8: every run that ends leaves complete set
    a_r8_end_sets_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_o) |-> done_o);
    // R3: addresses never leave the latched range
    a_r3_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o || mem_re_o) |-> (mem_addr_o <= seq_q.last));
    // R6: no write and read in the same cycle
    a_r6_we_re_apart: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({mem_we_o, mem_re_o}) <= 1);

endmodule

// File: rtl/sbist_ctl.sv
module sbist_ctl
    import sbist_pkg::*;
#(
    parameter int I_AW = 10,
    parameter int D_AW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              inst_use_en,
    output logic              data_use_en,
    output logic              inst_mem_we,
    output logic              inst_mem_re,
    output logic [I_AW-1:0]   inst_mem_addr,
    output logic [31:0]       inst_mem_wdata,
    input  logic [31:0]       inst_mem_rdata,
    output logic              data_mem_we,
    output logic              data_mem_re,
    output logic [D_AW-1:0]   data_mem_addr,
    output logic [31:0]       data_mem_wdata,
    input  logic [31:0]       data_mem_rdata
);
    typedef struct packed {
        sbist_cfg_t icfg;
        sbist_cfg_t dcfg;
    } ctl_state_t;

    ctl_state_t ctl_d, ctl_q;
    logic       i_start, d_start;
    logic       i_run, i_done, i_fail;
    logic       d_run, d_done, d_fail;
    logic       unused_rsvd_bits;

    assign unused_rsvd_bits = ^{cfg_wdata[20:19], cfg_wdata[4:3]};

    always_comb begin
        ctl_d   = ctl_q;
        i_start = 1'b0;
        d_start = 1'b0;
        if (cfg_we) begin
            ctl_d.icfg = '{size: cfg_wdata[31:21], en: cfg_wdata[18], pause: cfg_wdata[17]};
            ctl_d.dcfg = '{size: cfg_wdata[15:5],  en: cfg_wdata[2],  pause: cfg_wdata[1]};
            i_start    = cfg_wdata[16] && ctl_q.icfg.en && !i_run;
            d_start    = cfg_wdata[0]  && ctl_q.dcfg.en && !d_run;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    sbist_seq #(.AW(I_AW)) u_inst_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (i_start),
        .pause_i     (ctl_q.icfg.pause),
        .size_i      (ctl_d.icfg.size),
        .run_o       (i_run),
        .done_o      (i_done),
        .fail_o      (i_fail),
        .mem_we_o    (inst_mem_we),
        .mem_re_o    (inst_mem_re),
        .mem_addr_o  (inst_mem_addr),
        .mem_wdata_o (inst_mem_wdata),
        .mem_rdata_i (inst_mem_rdata)
    );

    sbist_seq #(.AW(D_AW)) u_data_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (d_start),
        .pause_i     (ctl_q.dcfg.pause),
        .size_i      (ctl_d.dcfg.size),
        .run_o       (d_run),
        .done_o      (d_done),
        .fail_o      (d_fail),
        .mem_we_o    (data_mem_we),
        .mem_re_o    (data_mem_re),
        .mem_addr_o  (data_mem_addr),
        .mem_wdata_o (data_mem_wdata),
        .mem_rdata_i (data_mem_rdata)
    );

    assign cfg_rdata = {ctl_q.icfg.size, i_done, i_fail, ctl_q.icfg.en, ctl_q.icfg.pause, i_run,
                        ctl_q.dcfg.size, d_done, d_fail, ctl_q.dcfg.en, ctl_q.dcfg.pause, d_run};

    assign inst_use_en = !ctl_q.icfg.en;
    assign data_use_en = !ctl_q.dcfg.en;

    // R4: a run only begins when enable was set beforehand
    a_r4_inst_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(i_run) |-> $past(ctl_q.icfg.en));
    a_r4_data_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(d_run) |-> $past(ctl_q.dcfg.en));
    // R5: test traffic only while the memory is withheld from normal use
    a_r5_inst_withheld: assert property (@(posedge clk) disable iff (!rst_n)
        (inst_mem_we || inst_mem_re) |-> !inst_use_en);
    a_r5_data_withheld: assert property (@(posedge clk) disable iff (!rst_n)
        (data_mem_we || data_mem_re) |-> !data_use_en);

endmodule

// File: tb/sbist_ctl_tb.sv
module sbist_ctl_tb;
    localparam int IAW = 6;
    localparam int DAW = 4;
    localparam int NV  = 6;
    localparam logic [31:0] VW [NV] = '{32'h0000_0000, 32'hFFFE_FFFE, 32'h0018_001C,
                                        32'h0030_0060, 32'h5556_AAA8, 32'h0000_0000};
    localparam logic [31:0] VR [NV] = '{32'h0000_0000, 32'hFFE6_FFE6, 32'h0000_0004,
                                        32'h0020_0060, 32'h5546_AAA0, 32'h0000_0000};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic inst_use_en, data_use_en;
    logic inst_mem_we, inst_mem_re, data_mem_we, data_mem_re;
    logic [IAW-1:0] inst_mem_addr;
    logic [DAW-1:0] data_mem_addr;
    logic [31:0] inst_mem_wdata, data_mem_wdata;
    logic [31:0] inst_mem_rdata = '0;
    logic [31:0] data_mem_rdata = '0;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    logic [31:0] imem [1<<IAW];
    logic [31:0] dmem [1<<DAW];
    logic clr = 1'b0;
    logic d_fault = 1'b0;
    int i_wr, i_rd, d_wr, d_rd, pat_err;

    always #4 clk = ~clk;

    sbist_ctl #(.I_AW(IAW), .D_AW(DAW)) u_dut (.*);

    function automatic logic [31:0] pat(input logic [31:0] a);
        return (a << 16) ^ ~a ^ 32'h3C3C_A5A5;
    endfunction

    function automatic logic [31:0] cw(input int isz, input bit ien, input bit ipa, input bit ist,
                                       input int dsz, input bit den, input bit dpa, input bit dst);
        return {11'(isz), 2'b00, ien, ipa, ist, 11'(dsz), 2'b00, den, dpa, dst};
    endfunction

    always @(posedge clk) begin
        if (clr) begin
            i_wr <= 0; i_rd <= 0; d_wr <= 0; d_rd <= 0; pat_err <= 0;
        end else begin
            if (inst_mem_we) begin
                imem[inst_mem_addr] <= inst_mem_wdata;
                if (inst_mem_wdata != pat(32'(inst_mem_addr)) || 32'(inst_mem_addr) != i_wr) pat_err <= pat_err + 1;
                i_wr <= i_wr + 1;
            end
            if (inst_mem_re) begin
                inst_mem_rdata <= imem[inst_mem_addr];
                if (32'(inst_mem_addr) != i_rd) pat_err <= pat_err + 1;
                i_rd <= i_rd + 1;
            end
            if (data_mem_we) begin
                dmem[data_mem_addr] <= data_mem_wdata;
                if (data_mem_wdata != pat(32'(data_mem_addr)) || 32'(data_mem_addr) != d_wr) pat_err <= pat_err + 1;
                d_wr <= d_wr + 1;
            end
            if (data_mem_re) begin
                data_mem_rdata <= dmem[data_mem_addr] ^ ((d_fault && data_mem_addr == 2) ? 32'h20 : 32'h0);
                if (32'(data_mem_addr) != d_rd) pat_err <= pat_err + 1;
                d_rd <= d_rd + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic clear_counts();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    // count cycles while a running bit stays high
    task automatic run_len(input int bitpos, output int n);
        n = 0;
        while (cfg_rdata[bitpos] && n < 1000) begin
            @(negedge clk); n++;
        end
    endtask

    task automatic data_run(input int sz, input int exp_len, input string req);
        int n;
        wr(cw(0, 0, 0, 0, sz, 1, 0, 0));
        clear_counts();
        wr(cw(0, 0, 0, 0, sz, 1, 0, 1));
        run_len(0, n);
        chk(n == exp_len, req, 32'(n), 32'(exp_len));
        chk(d_wr == (exp_len - 1) / 2 && d_rd == (exp_len - 1) / 2 && pat_err == 0, "R6",
            32'(d_wr), 32'((exp_len - 1) / 2));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        logic [31:0] snap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cfg_rdata == 32'h0, "R1", cfg_rdata, 32'h0);
        chk(inst_use_en && data_use_en, "R1", {30'd0, inst_use_en, data_use_en}, 32'h3);

        // R2 / R5 vector table
        for (int k = 0; k < NV; k++) begin
            wr(VW[k]);
            chk(cfg_rdata == VR[k], "R2", cfg_rdata, VR[k]);
            chk(inst_use_en == !VW[k][18] && data_use_en == !VW[k][2], "R5",
                {30'd0, inst_use_en, data_use_en}, {30'd0, !VW[k][18], !VW[k][2]});
        end

        // R4 start without prior enable is ignored
        clear_counts();
        wr(32'h0005_0005);
        snap = cfg_rdata;
        repeat (5) @(negedge clk);
        chk(snap[16] == 1'b0 && snap[0] == 1'b0 && i_wr == 0 && d_wr == 0, "R4", snap, 32'h0004_0004);
        wr(32'h0);

        // R3 run lengths, incl. clamp and zero size
        data_run(2, 9, "R3");
        chk(cfg_rdata[4] && !cfg_rdata[3], "R8", cfg_rdata, 32'h10);
        data_run(9, 33, "R3");
        data_run(0, 5, "R3");

        // R8 fault then clean rerun
        d_fault = 1'b1;
        wr(cw(0, 0, 0, 0, 3, 1, 0, 0));
        wr(cw(0, 0, 0, 0, 3, 1, 0, 1));
        run_len(0, n);
        chk(cfg_rdata[4] && cfg_rdata[3], "R8", cfg_rdata, 32'h18);
        d_fault = 1'b0;
        wr(cw(0, 0, 0, 0, 3, 1, 0, 1));
        chk(!cfg_rdata[4] && !cfg_rdata[3] && cfg_rdata[0], "R8", cfg_rdata, 32'h1);
        run_len(0, n);
        chk(cfg_rdata[4] && !cfg_rdata[3], "R8", cfg_rdata, 32'h10);

        // R7 pause and R4 restart while running ignored
        wr(cw(4, 1, 0, 0, 0, 0, 0, 0));
        clear_counts();
        wr(cw(4, 1, 0, 1, 0, 0, 0, 0));
        repeat (3) @(negedge clk);
        wr(cw(4, 1, 1, 0, 0, 0, 0, 0));
        snap = 32'(i_wr);
        repeat (10) @(negedge clk);
        chk(32'(i_wr) == snap && cfg_rdata[16], "R7", 32'(i_wr), snap);
        wr(cw(4, 1, 0, 1, 0, 0, 0, 0));
        run_len(16, n);
        chk(i_wr == 16 && i_rd == 16 && pat_err == 0, "R7", 32'(i_wr), 32'd16);
        chk(cfg_rdata[20] && !cfg_rdata[19], "R4", cfg_rdata, 32'h0010_0000);

        // R9 concurrent runs
        wr(cw(3, 1, 0, 0, 2, 1, 0, 0));
        wr(cw(3, 1, 0, 1, 2, 1, 0, 1));
        repeat (9) @(negedge clk);
        chk(!cfg_rdata[0] && cfg_rdata[4] && cfg_rdata[16], "R9", cfg_rdata, 32'h0001_0010);
        repeat (8) @(negedge clk);
        chk(!cfg_rdata[16] && cfg_rdata[20] && !cfg_rdata[19] && !cfg_rdata[3], "R9", cfg_rdata, 32'h0010_0010);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule